// File: doc/BRIEF.md
# Endpoint Flush Controller

This block lets software stop the transfers that are queued on a set of device endpoints. Each endpoint and direction owns one bit in a write-one-to-set request register and one bit in a primed status vector. Software writes ones to the endpoints it wants to cancel. The controller then handles every requested endpoint on its own. If the packet engine has no packet in flight to that endpoint, the controller clears the endpoint's primed bit. If a packet is in flight, the controller refuses the flush so that the packet can finish. In both cases it drops the request bit once that endpoint has been handled.

A refused flush can be told apart from a successful one because the primed bit is still set after the request bit has cleared. Software reads the status, sees which endpoints refused, and writes their request bits again. The packet engine marks its current target with a one-hot in-flight vector. The descriptor side sets primed bits through a set-pulse vector. A synchronous bus-reset input cancels everything at once. Bits `0..NUM_EP-1` belong to receive endpoints and bits `NUM_EP..2*NUM_EP-1` belong to transmit endpoints. The hardware treats every bit in the same way.

Top module: `ep_flush_top`

## Requirements
- R1: A write to address 0 sets each pending request bit whose data bit is 1. Data bits that are 0 leave their request bits unchanged. A read of address 0 returns the pending request bits, and they are visible in the cycle after the write.
- R2: A pending request whose endpoint has no packet in flight clears at the next clock edge. The endpoint's status bit clears at that same edge.
- R3: While the endpoint of a pending request has its in-flight bit high, the request stays pending and its status bit is unchanged, for any number of cycles.
- R4: When the in-flight bit of a held request falls, the request clears at the next edge and the status bit stays set. This is a refused flush.
- R5: A request written again after a refusal is handled afresh. With no packet in flight it succeeds and clears the status bit.
- R6: Requests for several endpoints are handled independently in the same cycle. Some can succeed while others are held.
- R7: A 1 on `primeSet` sets that status bit at the next edge. If a successful flush clears the same bit at that edge, the set wins.
- R8: `busReset` clears all pending requests and all status bits at the next edge. It overrides a request write and `primeSet` in the same cycle.
- R9: A read of address 1 returns the status vector. A read of any other address, or any cycle that is not a read, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address (0 request, 1 status) |
| busWdata | input | 2*NUM_EP | Write data |
| busRdata | output | 2*NUM_EP | Read data, combinational |
| primeSet | input | 2*NUM_EP | Per-endpoint pulse that sets the primed bit |
| inFlight | input | 2*NUM_EP | One-hot marker of the endpoint with a packet in progress |
| busReset | input | 1 | Synchronous clear of all requests and status |
| epStatus | output | 2*NUM_EP | Primed status vector |

## Verification
The assertions assume that the packet engine marks at most one endpoint as in flight at a time. They also assume that `busReset` is the only way status bits are lost other than a flush. The stimulus keeps to this by driving `inFlight` with zero or a single bit in every vector and directed case. Where an in-flight bit covers endpoints the bench has not requested, it still marks only one endpoint. The bench changes inputs only at the falling edge, so the in-flight bit is stable across each edge where a request is decided.

// File: rtl/epflush_pkg.sv
package epflush_pkg;

  localparam logic [1:0] ADDR_REQ    = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;

  // Per-endpoint strobes from control to datapath
  typedef struct packed {
    logic done;       // request handled this cycle, drop it
    logic clrStatus;  // flush accepted, clear primed bit
    logic markBusy;   // packet in flight, remember refusal
  } epStrobe_t;

endpackage

// File: rtl/ep_flush_ctrl.sv
module ep_flush_ctrl
  import epflush_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int W = 2 * NUM_EP
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [W-1:0]          pending,
  input  logic [W-1:0]          sawBusy,
  input  logic [W-1:0]          inFlight,
  output epStrobe_t [W-1:0]     strobes
);

  // One identical decision slice per endpoint bit
  for (genvar i = 0; i < W; i++) begin : g_ep
    always_comb begin
      strobes[i].markBusy  = pending[i] & inFlight[i];
      strobes[i].done      = pending[i] & ~inFlight[i];
      strobes[i].clrStatus = pending[i] & ~inFlight[i] & ~sawBusy[i];
    end
  end

  // Input assumption: the packet engine targets at most one endpoint (R3)
  p_inflight_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inFlight));

endmodule

// File: rtl/ep_flush_dp.sv
module ep_flush_dp
  import epflush_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int W = 2 * NUM_EP
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [1:0]            busAddr,
  input  logic [W-1:0]          busWdata,
  output logic [W-1:0]          busRdata,
  input  logic [W-1:0]          primeSet,
  input  logic [W-1:0]          inFlight,
  input  logic                  busReset,
  input  epStrobe_t [W-1:0]     strobes,
  output logic [W-1:0]          pending,
  output logic [W-1:0]          sawBusy,
  output logic [W-1:0]          status
);

  logic [W-1:0] setMask, doneV, clrV, busyV;
  logic [W-1:0] pendingNext, sawBusyNext, statusNext;

  for (genvar i = 0; i < W; i++) begin : g_unpack
    assign doneV[i] = strobes[i].done;
    assign clrV[i]  = strobes[i].clrStatus;
    assign busyV[i] = strobes[i].markBusy;
  end

  always_comb begin
    setMask = '0;
    if (busSel && busWrite && busAddr == ADDR_REQ) setMask = busWdata;
  end

  always_comb begin
    if (busReset) begin
      pendingNext = '0;
      sawBusyNext = '0;
      statusNext  = '0;
    end else begin
      pendingNext = (pending & ~doneV) | setMask;
      sawBusyNext = (sawBusy | busyV) & ~doneV;
      statusNext  = (status & ~clrV) | primeSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      sawBusy <= '0;
      status  <= '0;
    end else begin
      pending <= pendingNext;
      sawBusy <= sawBusyNext;
      status  <= statusNext;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      case (busAddr)
        ADDR_REQ:    busRdata = pending;
        ADDR_STATUS: busRdata = status;
        default:     busRdata = '0;
      endcase
    end
  end

  // R1: no request bit appears without a written one
  p_no_spurious_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(setMask)) == '0));

  // R3: a primed bit never drops for an endpoint that had a packet in flight
  p_no_clear_inflight_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busReset |=> ((($past(status) & ~status) & $past(inFlight)) == '0));

  // R2: a request without a packet in flight is gone one edge later
  p_req_drops_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busReset && setMask == '0) |=>
      (pending == ($past(pending) & $past(inFlight))));

  // R8: bus reset empties everything
  p_bus_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (pending == '0 && status == '0));

endmodule

// File: rtl/ep_flush_top.sv
module ep_flush_top
  import epflush_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [1:0]            busAddr,
  input  logic [2*NUM_EP-1:0]   busWdata,
  output logic [2*NUM_EP-1:0]   busRdata,
  input  logic [2*NUM_EP-1:0]   primeSet,
  input  logic [2*NUM_EP-1:0]   inFlight,
  input  logic                  busReset,
  output logic [2*NUM_EP-1:0]   epStatus
);

  localparam int W = 2 * NUM_EP;

  epStrobe_t [W-1:0] strobes;
  logic [W-1:0] pending, sawBusy;

  ep_flush_ctrl #(.NUM_EP(NUM_EP)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pending  (pending),
    .sawBusy  (sawBusy),
    .inFlight (inFlight),
    .strobes  (strobes)
  );

  ep_flush_dp #(.NUM_EP(NUM_EP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .primeSet (primeSet),
    .inFlight (inFlight),
    .busReset (busReset),
    .strobes  (strobes),
    .pending  (pending),
    .sawBusy  (sawBusy),
    .status   (epStatus)
  );

endmodule

// File: tb/ep_flush_top_tb.sv
module ep_flush_top_tb;

  localparam int NUM_EP = 4;
  localparam int W = 2 * NUM_EP;

  logic clk = 0, rstN = 0;
  logic busSel = 0, busWrite = 0, busReset = 0;
  logic [1:0] busAddr = 0;
  logic [W-1:0] busWdata = 0, primeSet = 0, inFlight = 0;
  logic [W-1:0] busRdata, epStatus;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ep_flush_top #(.NUM_EP(NUM_EP)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .primeSet(primeSet), .inFlight(inFlight), .busReset(busReset),
    .epStatus(epStatus)
  );

  // vector fields: prime[23:16], inFlight[15:8], write mask[7:0]
  localparam logic [23:0] VEC [6] = '{
    24'hFF_00_0F, 24'hFF_04_0C, 24'hA5_80_FF,
    24'h3C_00_00, 24'h00_01_01, 24'h81_01_81
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(logic [1:0] a, output logic [W-1:0] v);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 v = busRdata;
    busSel = 0; busAddr = 0;
  endtask

  task automatic writeReq(logic [W-1:0] m);
    busSel = 1; busWrite = 1; busAddr = 0; busWdata = m;
    tick();
    busSel = 0; busWrite = 0; busWdata = 0;
  endtask

  task automatic doBusReset();
    busReset = 1; tick(); busReset = 0;
  endtask

  task automatic prime(logic [W-1:0] m);
    primeSet = m; tick(); primeSet = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // reset state
    readReg(2'd0, v); check("R1 reset pending", v, '0);
    readReg(2'd1, v); check("R9 reset status", v, '0);

    // vector walk: R1 R2 R3 R4 R6 R7
    foreach (VEC[k]) begin
      logic [W-1:0] pm, fl, wm, expStat;
      pm = VEC[k][23:16]; fl = VEC[k][15:8]; wm = VEC[k][7:0];
      expStat = pm & ~(wm & ~fl);
      doBusReset();
      prime(pm);
      readReg(2'd1, v); check("R7 prime sets status", v, pm);
      inFlight = fl;
      writeReq(wm);
      readReg(2'd0, v); check("R1 pending after write", v, wm);
      tick();
      readReg(2'd0, v); check("R6 held vs cleared", v, wm & fl);
      readReg(2'd1, v); check("R2 status after flush", v, expStat);
      inFlight = 0;
      tick();
      readReg(2'd0, v); check("R4 request drops after packet", v, '0);
      readReg(2'd1, v); check("R4 refused status stays", v, expStat);
      check("R9 status port", epStatus, expStat);
    end

    // R9 unmapped address reads zero
    doBusReset(); prime(8'h5A); inFlight = 8'h02; writeReq(8'h02);
    readReg(2'd2, v); check("R9 unmapped addr", v, '0);
    readReg(2'd3, v); check("R9 unmapped addr 3", v, '0);

    // R3 held several cycles, R5 retry after refusal
    repeat (3) begin
      tick();
      readReg(2'd0, v); check("R3 held while in flight", v, 8'h02);
      check("R3 status unchanged", epStatus, 8'h5A);
    end
    inFlight = 0; tick();
    readReg(2'd0, v); check("R4 cleared", v, '0);
    check("R4 refused status", epStatus, 8'h5A);
    writeReq(8'h02);
    readReg(2'd0, v); check("R5 retry pending", v, 8'h02);
    tick();
    readReg(2'd0, v); check("R5 retry done", v, '0);
    check("R5 retry success", epStatus, 8'h58);

    // R7 prime wins over a concurrent clear
    doBusReset(); prime(8'h10); writeReq(8'h10);
    primeSet = 8'h10; tick(); primeSet = 0;
    readReg(2'd0, v); check("R7 request handled", v, '0);
    check("R7 prime wins", epStatus, 8'h10);

    // R8 bus reset beats write and prime
    prime(8'hFF); inFlight = 8'h01; writeReq(8'h03);
    busReset = 1; primeSet = 8'hFF;
    busSel = 1; busWrite = 1; busAddr = 0; busWdata = 8'h0C;
    tick();
    busReset = 0; primeSet = 0; busSel = 0; busWrite = 0; busWdata = 0;
    inFlight = 0;
    readReg(2'd0, v); check("R8 pending cleared", v, '0);
    check("R8 status cleared", epStatus, '0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule